// File: doc/BRIEF.md
# PCM Voice Serial Port

This block moves one audio sample per frame across a four-wire synchronous serial link made of a bit clock, a frame sync, a serial data output and a serial data input. It can drive the bit clock and frame sync itself as master. It can also follow a far-end device that supplies them, as slave. Two framing conventions are supported. In the long format, a rising sync edge opens the word. In the short format, the sync is high for one bit and its falling edge opens the word. Samples are 8 or 16 bits wide and move MSB first.

The block runs entirely on one system clock that is faster than the bit clock. The serial clock, sync and data input pass through a two-flop synchronizer and are then edge-detected into one-cycle enables. As master, a programmable divider makes the bit clock, with a half period of `cfg_half_div` system cycles, and a position counter makes frames of `cfg_frame_bits` bit clocks. For an 8 kHz frame at 2048 kHz this would be 256. The master's own clock and sync take the same synchronized path as an external pair would, so both modes share one framer.

The parallel side has a transmit holding register loaded by a `tx_valid` strobe, and a receive register announced by a one-cycle `rx_valid`. An output enable tells the pad when to drive the data pin.

Top module: `pcm_voice_port`

## Requirements
- R1: As master (`cfg_master`=1), `pcm_clk_out` stays high for `cfg_half_div` system cycles and low for `cfg_half_div` system cycles (`cfg_half_div` of 4 or more). A frame lasts `cfg_frame_bits` bit-clock periods.
- R2: As master in long format (`cfg_short_sync`=0), `pcm_sync_out` rises with the first bit clock of each frame and stays high for exactly 8 bit-clock periods.
- R3: As master in short format (`cfg_short_sync`=1), `pcm_sync_out` is high for exactly one bit-clock period, namely the last one of the frame.
- R4: A word starts at the bit-clock rising edge where sync rises (long format) or falls (short format). From that edge, `pcm_dout_oe` is 1 and the sample is driven MSB first, one new bit per rising edge. As slave in long format, a sync pulse of any width of two bit clocks or more is accepted, including one that outlasts the word.
- R5: `pcm_din` is sampled on bit-clock falling edges. A few system cycles after the falling edge of the last bit, `rx_data` is updated and `rx_valid` is high for exactly one cycle. With `cfg_wide`=0, `rx_data[15:8]` reads zero.
- R6: With `cfg_wide`=1 the word is 16 bits of `tx_data`. With `cfg_wide`=0 the word is `tx_data[7:0]`, 8 bits long.
- R7: With `cfg_hiz_late`=0, `pcm_dout_oe` falls at the falling bit-clock edge inside the LSB. With `cfg_hiz_late`=1, it stays high through that edge and falls at the next rising edge.
- R8: The value last written with `tx_valid` is latched at word start. If nothing was written since the previous word start, the previous sample is sent again and `underrun` pulses high for one cycle.
- R9: A word-start sync edge that arrives before the current word has finished restarts the word from its MSB and sets `framing_err`, which then stays set until reset.
- R10: While `rst_n` is low, and as slave, `pcm_clk_out` and `pcm_sync_out` are 0. During reset `pcm_dout_oe`, `pcm_dout`, `rx_valid`, `underrun` and `framing_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1: generate bit clock and sync; 0: follow external ones |
| cfg_short_sync | input | 1 | 0: long format (rising sync edge starts word); 1: short format |
| cfg_wide | input | 1 | 1: 16-bit samples; 0: 8-bit samples |
| cfg_hiz_late | input | 1 | 0: release data pin at LSB falling edge; 1: at following rising edge |
| cfg_half_div | input | DIV_W | Master bit-clock half period in system cycles |
| cfg_frame_bits | input | FRAME_W | Master frame length in bit clocks |
| pcm_clk_in | input | 1 | External bit clock (slave) |
| pcm_sync_in | input | 1 | External frame sync (slave) |
| pcm_din | input | 1 | Serial data input |
| pcm_clk_out | output | 1 | Generated bit clock (master) |
| pcm_sync_out | output | 1 | Generated frame sync (master) |
| pcm_dout | output | 1 | Serial data output |
| pcm_dout_oe | output | 1 | Drive enable for the data output pad |
| tx_data | input | 16 | Sample to transmit |
| tx_valid | input | 1 | Write strobe for `tx_data` |
| rx_data | output | 16 | Last received sample |
| rx_valid | output | 1 | One-cycle strobe when `rx_data` updates |
| underrun | output | 1 | One-cycle pulse: sample repeated at word start |
| framing_err | output | 1 | Sticky: early sync seen inside a word |

## Verification
In master mode the framer is driven by its own generator in both formats and at both widths. This shows whether the sync width, the frame length and the word-start edge follow the format bit rather than the mode. In slave mode the bench drives sync pulses of two bits and of twelve bits, the latter outlasting an 8-bit word. This separates edge detection from level detection. Each data word mixes ones and zeros in both halves, so that a byte swap, a reversed bit order or a lost upper byte shows up in the scoreboard. Separate frames cover a missing transmit write, both data-pin release settings and a sync that restarts a word early; each isolates the flag or enable edge it should move.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  localparam int SAMPLE_W       = 16;
  localparam int NARROW_W       = 8;
  localparam int IDX_W          = $clog2(SAMPLE_W);
  localparam int LONG_SYNC_BITS = 8;

  // Place the sample so that its MSB sits at the top of the shifter.
  function automatic logic [SAMPLE_W-1:0] load_word(input logic [SAMPLE_W-1:0] d,
                                                     input logic wide);
    return wide ? d : {d[NARROW_W-1:0], {(SAMPLE_W-NARROW_W){1'b0}}};
  endfunction

  // Present a received word right-aligned, zero above an 8-bit sample.
  function automatic logic [SAMPLE_W-1:0] rx_present(input logic [SAMPLE_W-1:0] sh,
                                                      input logic wide);
    return wide ? sh : {{(SAMPLE_W-NARROW_W){1'b0}}, sh[NARROW_W-1:0]};
  endfunction

  function automatic logic [IDX_W-1:0] last_bit(input logic wide);
    return wide ? IDX_W'(SAMPLE_W-1) : IDX_W'(NARROW_W-1);
  endfunction

  // Word start rule at a bit-clock rising edge.
  function automatic logic is_word_start(input logic short_fmt, input logic now,
                                         input logic prev);
    return short_fmt ? (prev & ~now) : (now & ~prev);
  endfunction
endpackage

// File: rtl/pcm_sync_chain.sv
module pcm_sync_chain #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pcm_clkgen.sv
module pcm_clkgen import pcm_pkg::*; #(
  parameter int DIV_W   = 8,
  parameter int FRAME_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               short_fmt,
  input  logic [DIV_W-1:0]   half_div,
  input  logic [FRAME_W-1:0] frame_bits,
  output logic               bclk,
  output logic               fsync
);
  localparam logic [FRAME_W-1:0] ONE_F  = FRAME_W'(1);
  localparam logic [FRAME_W-1:0] LONG_F = FRAME_W'(LONG_SYNC_BITS);

  logic [DIV_W-1:0]   div_cnt;
  logic [DIV_W:0]     cnt_next;
  logic [FRAME_W-1:0] pos, pos_next, last_pos;
  logic               tick, gen_rise;

  assign cnt_next = {1'b0, div_cnt} + 1'b1;
  assign tick     = en && (cnt_next >= {1'b0, half_div});
  assign gen_rise = tick && !bclk;
  assign last_pos = frame_bits - ONE_F;
  assign pos_next = (pos >= last_pos) ? '0 : pos + ONE_F;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      bclk    <= 1'b0;
      fsync   <= 1'b0;
      pos     <= '1;
    end else if (!en) begin
      div_cnt <= '0;
      bclk    <= 1'b0;
      fsync   <= 1'b0;
      pos     <= '1;
    end else begin
      if (tick) begin
        div_cnt <= '0;
        bclk    <= ~bclk;
      end else begin
        div_cnt <= cnt_next[DIV_W-1:0];
      end
      if (gen_rise) begin
        pos   <= pos_next;
        fsync <= short_fmt ? (pos_next == last_pos) : (pos_next < LONG_F);
      end
    end
  end

  // R1: the bit clock only moves when the divider expires
  a_r1_clk_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(bclk));
  // R2, R3: the sync only changes together with a generated rising edge
  a_r2_sync_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !$stable(fsync)) |-> $past(gen_rise));
endmodule

// File: rtl/pcm_framer.sv
module pcm_framer import pcm_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                short_fmt,
  input  logic                wide,
  input  logic                hiz_late,
  input  logic                bclk_s,
  input  logic                sync_s,
  input  logic                din_s,
  input  logic [SAMPLE_W-1:0] tx_data,
  input  logic                tx_valid,
  output logic                dout,
  output logic                dout_oe,
  output logic [SAMPLE_W-1:0] rx_data,
  output logic                rx_valid,
  output logic                underrun,
  output logic                framing_err
);
  logic                bclk_d, sync_prev, active, tx_fresh, late_release;
  logic [IDX_W-1:0]    bit_idx;
  logic [SAMPLE_W-1:0] tx_sh, rx_sh, tx_hold, rx_next;

  // named internal events
  logic bit_rise, bit_fall, word_start, lsb_fall, early_sync;
  assign bit_rise   = bclk_s & ~bclk_d;
  assign bit_fall   = ~bclk_s & bclk_d;
  assign word_start = bit_rise && is_word_start(short_fmt, sync_s, sync_prev);
  assign lsb_fall   = bit_fall && active && (bit_idx == last_bit(wide));
  assign early_sync = word_start && active;
  assign rx_next    = {rx_sh[SAMPLE_W-2:0], din_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d       <= 1'b0;
      sync_prev    <= 1'b0;
      active       <= 1'b0;
      tx_fresh     <= 1'b0;
      late_release <= 1'b0;
      bit_idx      <= '0;
      tx_sh        <= '0;
      rx_sh        <= '0;
      tx_hold      <= '0;
      rx_data      <= '0;
      rx_valid     <= 1'b0;
      underrun     <= 1'b0;
      framing_err  <= 1'b0;
      dout_oe      <= 1'b0;
    end else begin
      bclk_d   <= bclk_s;
      rx_valid <= 1'b0;
      underrun <= 1'b0;
      if (bit_rise) sync_prev <= sync_s;
      if (tx_valid) begin
        tx_hold  <= tx_data;
        tx_fresh <= 1'b1;
      end
      if (word_start) begin
        tx_sh        <= load_word(tx_hold, wide);
        active       <= 1'b1;
        bit_idx      <= '0;
        dout_oe      <= 1'b1;
        late_release <= 1'b0;
        underrun     <= ~tx_fresh;
        tx_fresh     <= tx_valid;
        if (active) framing_err <= 1'b1;
      end else if (bit_rise) begin
        if (active) begin
          tx_sh   <= tx_sh << 1;
          bit_idx <= bit_idx + 1'b1;
        end
        if (late_release) begin
          dout_oe      <= 1'b0;
          late_release <= 1'b0;
        end
      end
      if (bit_fall && active) begin
        rx_sh <= rx_next;
        if (lsb_fall) begin
          active   <= 1'b0;
          rx_valid <= 1'b1;
          rx_data  <= rx_present(rx_next, wide);
          if (hiz_late) late_release <= 1'b1;
          else          dout_oe      <= 1'b0;
        end
      end
    end
  end

  assign dout = dout_oe & tx_sh[SAMPLE_W-1];

  // R4: the pin is driven right after a word start
  a_r4_drive_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    word_start |=> dout_oe);
  // R5: receive strobe is a single cycle following a falling edge
  a_r5_rx_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r5_rx_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(bit_fall));
  // R7: release timing after the LSB
  a_r7_early_release: assert property (@(posedge clk) disable iff (!rst_n)
    (lsb_fall && !hiz_late) |=> !dout_oe);
  a_r7_late_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lsb_fall && hiz_late) |=> dout_oe);
  // R8: underrun only pulses at a word start
  a_r8_underrun_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> $past(word_start));
  // R9: early sync flags and the flag stays
  a_r9_early_flags: assert property (@(posedge clk) disable iff (!rst_n)
    early_sync |=> framing_err);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    framing_err |=> framing_err);
endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port import pcm_pkg::*; #(
  parameter int DIV_W   = 8,
  parameter int FRAME_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_master,
  input  logic                cfg_short_sync,
  input  logic                cfg_wide,
  input  logic                cfg_hiz_late,
  input  logic [DIV_W-1:0]    cfg_half_div,
  input  logic [FRAME_W-1:0]  cfg_frame_bits,
  input  logic                pcm_clk_in,
  input  logic                pcm_sync_in,
  input  logic                pcm_din,
  output logic                pcm_clk_out,
  output logic                pcm_sync_out,
  output logic                pcm_dout,
  output logic                pcm_dout_oe,
  input  logic [SAMPLE_W-1:0] tx_data,
  input  logic                tx_valid,
  output logic [SAMPLE_W-1:0] rx_data,
  output logic                rx_valid,
  output logic                underrun,
  output logic                framing_err
);
  localparam int SYNC_STAGES = 2;

  logic       gen_bclk, gen_sync;
  logic [2:0] raw_pins, synced_pins;

  pcm_clkgen #(.DIV_W(DIV_W), .FRAME_W(FRAME_W)) u_clkgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (cfg_master),
    .short_fmt  (cfg_short_sync),
    .half_div   (cfg_half_div),
    .frame_bits (cfg_frame_bits),
    .bclk       (gen_bclk),
    .fsync      (gen_sync)
  );

  // Own or external clock/sync take the same synchronized route.
  assign raw_pins = cfg_master ? {gen_bclk, gen_sync, pcm_din}
                               : {pcm_clk_in, pcm_sync_in, pcm_din};

  pcm_sync_chain #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_pins),
    .q     (synced_pins)
  );

  pcm_framer u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .short_fmt   (cfg_short_sync),
    .wide        (cfg_wide),
    .hiz_late    (cfg_hiz_late),
    .bclk_s      (synced_pins[2]),
    .sync_s      (synced_pins[1]),
    .din_s       (synced_pins[0]),
    .tx_data     (tx_data),
    .tx_valid    (tx_valid),
    .dout        (pcm_dout),
    .dout_oe     (pcm_dout_oe),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid),
    .underrun    (underrun),
    .framing_err (framing_err)
  );

  assign pcm_clk_out  = gen_bclk;
  assign pcm_sync_out = gen_sync;

  // R10: nothing is generated while acting as slave
  a_r10_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_master && !$past(cfg_master)) |-> (!pcm_clk_out && !pcm_sync_out));
endmodule

// File: tb/test_pcm_voice_port.sv
module test_pcm_voice_port;
  localparam int CLK_PERIOD = 10;
  localparam int SLV_HALF   = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_master = 1'b0, cfg_short_sync = 1'b0, cfg_wide = 1'b1, cfg_hiz_late = 1'b0;
  logic [7:0]  cfg_half_div = 8'd5;
  logic [8:0]  cfg_frame_bits = 9'd24;
  logic        pcm_clk_in = 1'b0, pcm_sync_in = 1'b0, pcm_din = 1'b0;
  logic        pcm_clk_out, pcm_sync_out, pcm_dout, pcm_dout_oe;
  logic [15:0] tx_data = 16'h0;
  logic        tx_valid = 1'b0;
  logic [15:0] rx_data;
  logic        rx_valid, underrun, framing_err;

  pcm_voice_port i_pcm_voice_port (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_short_sync(cfg_short_sync),
    .cfg_wide(cfg_wide), .cfg_hiz_late(cfg_hiz_late), .cfg_half_div(cfg_half_div),
    .cfg_frame_bits(cfg_frame_bits), .pcm_clk_in(pcm_clk_in), .pcm_sync_in(pcm_sync_in),
    .pcm_din(pcm_din), .pcm_clk_out(pcm_clk_out), .pcm_sync_out(pcm_sync_out),
    .pcm_dout(pcm_dout), .pcm_dout_oe(pcm_dout_oe), .tx_data(tx_data), .tx_valid(tx_valid),
    .rx_data(rx_data), .rx_valid(rx_valid), .underrun(underrun), .framing_err(framing_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  logic [15:0] exp_rx[$];
  logic [15:0] exp_tx[$];
  int ur_count = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Expected word on the wire / at rx_data, restated with masks.
  function automatic logic [15:0] wire_word(input logic [15:0] d, input logic wide);
    return d & (wide ? 16'hFFFF : 16'h00FF);
  endfunction

  // Scoreboard monitor for received samples (R5)
  always @(negedge clk) begin
    cyc++;
    if (rst_n && underrun) ur_count++;
    if (rst_n && rx_valid) begin
      if (exp_rx.size() == 0) check(1'b0, "R5 unexpected rx_valid", {16'h0, rx_data}, 32'h0);
      else begin
        logic [15:0] e;
        e = exp_rx.pop_front();
        check(rx_data == e, "R5 rx_data", {16'h0, rx_data}, {16'h0, e});
      end
    end
  end

  // Master-side line monitor: period, sync run, frame length, word starts
  int m_starts = 0, m_period = 0, m_run = 0, m_last_run = 0, m_since = 0, m_frame_len = 0;
  int m_last_rise = 0;
  logic m_clk_q = 1'b0, m_sync_q = 1'b0;
  always begin
    @(posedge clk);
    #2;
    if (rst_n && cfg_master) begin
      if (pcm_clk_out && !m_clk_q) begin
        m_period = cyc - m_last_rise;
        m_last_rise = cyc;
        m_since++;
        if (pcm_sync_out) m_run++;
        else if (m_sync_q) begin m_last_run = m_run; m_run = 0; end
        if (cfg_short_sync ? (m_sync_q && !pcm_sync_out) : (pcm_sync_out && !m_sync_q)) begin
          m_frame_len = m_since;
          m_since = 0;
          m_starts++;
        end
        m_sync_q = pcm_sync_out;
      end
      m_clk_q = pcm_clk_out;
    end
  end

  task automatic do_reset(input logic master, input logic short_f, input logic wide,
                          input logic late, input logic [7:0] half, input logic [8:0] frame);
    rst_n = 1'b0;
    cfg_master = master; cfg_short_sync = short_f; cfg_wide = wide; cfg_hiz_late = late;
    cfg_half_div = half; cfg_frame_bits = frame;
    pcm_clk_in = 1'b0; pcm_sync_in = 1'b0; pcm_din = 1'b0; tx_valid = 1'b0;
    m_starts = 0; m_run = 0; m_last_run = 0; m_since = 0; m_frame_len = 0;
    m_clk_q = 1'b0; m_sync_q = 1'b0; m_last_rise = cyc;
    wait_cyc(3);
    check(!pcm_dout_oe && !pcm_dout && !rx_valid && !underrun && !framing_err &&
          !pcm_clk_out && !pcm_sync_out, "R10 reset state",
          {25'h0, pcm_dout_oe, pcm_dout, rx_valid, underrun, framing_err, pcm_clk_out, pcm_sync_out},
          32'h0);
    rst_n = 1'b1;
    wait_cyc(1);
  endtask

  // Driver: write a sample and push its expectation
  task automatic write_tx(input logic [15:0] d);
    tx_data = d; tx_valid = 1'b1;
    wait_cyc(1);
    tx_valid = 1'b0;
    exp_tx.push_back(d);
  endtask

  // One slave bit clock: rising edge with new data/sync, dout sampled late in high phase
  task automatic slave_bit(input logic d, input logic s, output logic got, output logic oe);
    pcm_clk_in = 1'b1; pcm_din = d; pcm_sync_in = s;
    wait_cyc(SLV_HALF - 1);
    got = pcm_dout; oe = pcm_dout_oe;
    wait_cyc(1);
    pcm_clk_in = 1'b0;
    wait_cyc(SLV_HALF);
  endtask

  task automatic slave_frame(input logic [15:0] rxw, input int sync_len, input string tag);
    int n;
    logic g, o, all_oe;
    logic [15:0] word, e;
    n = cfg_wide ? 16 : 8;
    word = '0; all_oe = 1'b1;
    exp_rx.push_back(wire_word(rxw, cfg_wide));
    if (cfg_short_sync) slave_bit(1'b0, 1'b1, g, o);
    for (int i = 0; i < n; i++) begin
      slave_bit(rxw[n-1-i], (!cfg_short_sync && i < sync_len), g, o);
      word = {word[14:0], g};
      all_oe = all_oe & o;
    end
    check(all_oe, {"R4 oe during word ", tag}, {31'h0, all_oe}, 32'h1);
    if (cfg_hiz_late) begin
      check(pcm_dout_oe, {"R7 late release holds ", tag}, {31'h0, pcm_dout_oe}, 32'h1);
      slave_bit(1'b0, (!cfg_short_sync && n < sync_len), g, o);
      check(!pcm_dout_oe, {"R7 late release drops ", tag}, {31'h0, pcm_dout_oe}, 32'h0);
    end else begin
      check(!pcm_dout_oe, {"R7 early release ", tag}, {31'h0, pcm_dout_oe}, 32'h0);
      slave_bit(1'b0, (!cfg_short_sync && n < sync_len), g, o);
    end
    for (int j = 1; j < 8; j++) slave_bit(1'b0, (!cfg_short_sync && n + j < sync_len), g, o);
    if (exp_tx.size() == 0) check(1'b0, {"R6 no tx expectation ", tag}, 32'h0, 32'h0);
    else begin
      e = wire_word(exp_tx.pop_front(), cfg_wide);
      check(word == e, {"R6 R4 tx word ", tag}, {16'h0, word}, {16'h0, e});
    end
  endtask

  // Master: wait for a word start seen on the generated lines, act as far end
  task automatic master_word(input logic [15:0] rxw, input string tag);
    int n, s0;
    logic [15:0] word, e;
    n = cfg_wide ? 16 : 8;
    word = '0;
    s0 = m_starts;
    exp_rx.push_back(wire_word(rxw, cfg_wide));
    while (m_starts == s0) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      pcm_din = rxw[n-1-i];
      while (pcm_clk_out) @(negedge clk);
      word = {word[14:0], pcm_dout};
      if (i < n - 1) while (!pcm_clk_out) @(negedge clk);
    end
    wait_cyc(6);
    if (exp_tx.size() == 0) check(1'b0, {"R6 no tx expectation ", tag}, 32'h0, 32'h0);
    else begin
      e = wire_word(exp_tx.pop_front(), cfg_wide);
      check(word == e, {"R4 R6 master tx word ", tag}, {16'h0, word}, {16'h0, e});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int u0;
    // ---------- master, long format, 16-bit ----------
    do_reset(1'b1, 1'b0, 1'b1, 1'b0, 8'd5, 9'd24);
    write_tx(16'hA1B2);
    master_word(16'h5A3C, "m-long-1");
    write_tx(16'h1357);
    master_word(16'hC0DE, "m-long-2");
    check(m_period == 10, "R1 bit period", m_period, 10);
    check(m_frame_len == 24, "R1 frame length", m_frame_len, 24);
    check(m_last_run == 8, "R2 long sync width", m_last_run, 8);
    u0 = ur_count;
    exp_tx.push_back(16'h1357);                  // R8: nothing written, repeat
    master_word(16'h0F0F, "m-underrun");
    check(ur_count - u0 == 1, "R8 underrun pulse", ur_count - u0, 1);

    // ---------- master, short format, 8-bit ----------
    do_reset(1'b1, 1'b1, 1'b0, 1'b0, 8'd5, 9'd20);
    write_tx(16'h00C3);
    master_word(16'h0096, "m-short-1");
    write_tx(16'hFF5A);
    master_word(16'hFF3C, "m-short-2");
    check(m_last_run == 1, "R3 short sync width", m_last_run, 1);
    check(m_frame_len == 20, "R1 frame length short", m_frame_len, 20);

    // ---------- slave, long, 16-bit, early release ----------
    do_reset(1'b0, 1'b0, 1'b1, 1'b0, 8'd5, 9'd24);
    wait_cyc(4);
    check(!pcm_clk_out && !pcm_sync_out, "R10 slave outputs quiet",
          {30'h0, pcm_clk_out, pcm_sync_out}, 32'h0);
    write_tx(16'h8421);
    slave_frame(16'h3C96, 2, "s-long-2bit");
    // late release, sync wider than the word
    cfg_hiz_late = 1'b1;
    write_tx(16'h7E01);
    slave_frame(16'hB44D, 20, "s-long-wide-late");
    cfg_hiz_late = 1'b0;
    // 8-bit, long sync outlasting the word (R4), zero upper rx byte (R5)
    cfg_wide = 1'b0;
    write_tx(16'h12A5);
    slave_frame(16'hFF3C, 12, "s-long-8bit");
    // short format, 16-bit
    cfg_short_sync = 1'b1; cfg_wide = 1'b1;
    write_tx(16'hBEEF);
    slave_frame(16'h6A17, 0, "s-short");
    // underrun in slave mode
    u0 = ur_count;
    exp_tx.push_back(16'hBEEF);
    slave_frame(16'h0123, 0, "s-short-underrun");
    check(ur_count - u0 == 1, "R8 slave underrun", ur_count - u0, 1);

    // ---------- R9: early sync restarts word ----------
    cfg_short_sync = 1'b0;
    check(!framing_err, "R9 no error before", {31'h0, framing_err}, 32'h0);
    write_tx(16'h0F0F);
    begin
      logic g, o;
      slave_bit(1'b1, 1'b1, g, o);
      slave_bit(1'b0, 1'b1, g, o);
      slave_bit(1'b1, 1'b0, g, o);
      slave_bit(1'b1, 1'b0, g, o);
    end
    slave_frame(16'hE24B, 2, "s-restart");
    check(framing_err, "R9 framing error set", {31'h0, framing_err}, 32'h1);
    write_tx(16'h5555);
    slave_frame(16'h9999, 3, "s-after-error");
    check(framing_err, "R9 framing error sticky", {31'h0, framing_err}, 32'h1);

    wait_cyc(4);
    check(exp_rx.size() == 0, "R5 all rx words delivered", exp_rx.size(), 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule